// File: doc/BRIEF.md
# Codec-Side Serial Audio Link Frame Engine

This block is the codec end of a fixed-rate, full-duplex, time-division-multiplexed audio link. Each frame has a 16-bit tag slot followed by twelve 20-bit slots. The controller marks each frame start with a rise of its frame-sync line. The engine splits the incoming serial stream into slots. It passes on only the command slots and the four playback sample slots, and each one leaves with a single-cycle strobe. At the same time it builds the return stream. That stream carries a readiness flag, per-slot valid tags, an echo of the register status, and left and right capture samples. Any position that has nothing to carry is sent as zero.

The serial bit clock is not a real clock here. It appears as two enables on the system clock: one marks the rising bit-clock edge, when this side launches a bit, and one marks the falling edge, when this side samples a bit. Register decoding, the analog path, rate conversion and the link's reset sequencing are left to neighbouring logic.

Top module: `aclink_frame_engine`

## Requirements
- R1: A sync rise is recognised at the first falling-edge enable where `syncIn` is 1 after having been 0. The next rising-edge enable drives bit 15 of the tag slot. After that the engine steps through a 16-bit tag slot and then slots 1 to 12 of 20 bits each, MSB first.
- R2: `txData` changes only in the cycle after a `riseEn` cycle. Incoming bits, including `syncIn`, are taken only on `fallEn` cycles.
- R3: The return tag slot, sent MSB first, is laid out as follows. Bit 15 is `codecReady`. Bits 14 and 13 (tags for slots 1 and 2) equal the latched `statusValid`. Bits 12 and 11 (tags for slots 3 and 4) equal the latched `captureValid`. Bits 10 to 0 are 0.
- R4: Return slot 1 is a 0, then the 7-bit `statusIndex`, then 12 zeros. Return slot 2 is the 16-bit `statusData` followed by 4 zeros. Both slots are all zero when the latched `statusValid` is 0.
- R5: Return slots 3 and 4 carry the 18-bit left and right capture samples MSB first, each followed by two zero bits. Both are all zero when `captureValid` is 0. Return slots 5 to 12 are always zero.
- R6: All return-side inputs are latched on the `fallEn` cycle that sees the sync rise. A change made in the middle of a frame reaches only the next frame.
- R7: Incoming slots 1, 2, 3, 4, 7 and 8 map to `slotStrobe` bits 0 to 5 in that order. A strobe bit pulses for one cycle, in the cycle after the `fallEn` that samples the slot's last bit. `slotWord` then holds the slot's 20 received bits. The pulse is given only when incoming tag-slot bit 15 (frame valid) and that slot's tag bit (bit 15 minus the slot number) are both 1.
- R8: The tag slot and incoming slots 5, 6 and 9 to 12 never raise a strobe. Neither does an untagged slot, nor any slot in a frame whose frame-valid bit is 0. At most one strobe bit is high at a time.
- R9: A sync rise seen in the middle of a frame starts a new frame at once. The slot count restarts from the tag slot.
- R10: If no new sync rise comes by the end of slot 12, the engine goes idle. While idle, `txData` is driven 0 and no strobe fires until the next sync rise.
- R11: While and after reset, `txData` is 0 and `slotStrobe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| riseEn | input | 1 | Rising bit-clock edge enable (launch) |
| fallEn | input | 1 | Falling bit-clock edge enable (sample) |
| syncIn | input | 1 | Frame sync from the controller |
| rxData | input | 1 | Serial stream from the controller |
| txData | output | 1 | Serial stream to the controller |
| codecReady | input | 1 | Readiness flag for the return tag slot |
| statusValid | input | 1 | A status reply goes in the next frame |
| statusIndex | input | 7 | Register index echoed in return slot 1 |
| statusData | input | 16 | Register data for return slot 2 |
| captureValid | input | 1 | Capture samples are valid for the next frame |
| captureLeft | input | CAP_W | Left capture sample |
| captureRight | input | CAP_W | Right capture sample |
| slotStrobe | output | 6 | One-cycle strobes for slots 1, 2, 3, 4, 7, 8 |
| slotWord | output | 20 | Received word of the slot just strobed |

## Verification
Three situations are hard to reach from the ports. The first is a sync rise that lands in the middle of a frame, which must realign counting without losing the bit sampled at that edge. The second is a return-side input that changes while its own slot is being shifted out. The bench sends one frame cut short at bit 99 with a fresh sync rise. It also changes the capture inputs at bit 60, which falls inside return slot 3, and expects the old sample to finish and the new one to appear one frame later. Frames with the valid bit clear, or with only the ignored slots tagged, cover the strobe gating.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  localparam int TAG_W      = 16;
  localparam int SLOT_W     = 20;
  localparam int NUM_SLOTS  = 12;
  localparam int SLOT_IDX_W = $clog2(NUM_SLOTS + 2);
  localparam int BIT_IDX_W  = $clog2(SLOT_W);
  localparam int NUM_FWD    = 6;
  // incoming slots forwarded, in strobe-bit order
  localparam int FWD_SLOT [NUM_FWD] = '{1, 2, 3, 4, 7, 8};

  typedef struct packed {
    logic                  launch;     // rising bit-clock enable
    logic                  active;     // inside a frame
    logic                  sample;     // falling enable while active
    logic                  slotEnd;    // last bit of current slot sampled
    logic                  frameStart; // sync rise sampled
    logic [SLOT_IDX_W-1:0] slot;
    logic [BIT_IDX_W-1:0]  bitIdx;
  } linkStrobes_t;
endpackage

// File: rtl/aclink_control.sv
module aclink_control
  import aclink_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         riseEn,
  input  logic         fallEn,
  input  logic         syncIn,
  output linkStrobes_t stb
);
  logic                  syncSeen, active, syncRise, lastBit;
  logic [SLOT_IDX_W-1:0] slotCnt;
  logic [BIT_IDX_W-1:0]  bitCnt;

  always_comb begin
    syncRise       = fallEn && syncIn && !syncSeen;
    lastBit        = (slotCnt == '0) ? (bitCnt == BIT_IDX_W'(TAG_W - 1))
                                     : (bitCnt == BIT_IDX_W'(SLOT_W - 1));
    stb.launch     = riseEn;
    stb.active     = active;
    stb.sample     = fallEn && active;
    stb.slotEnd    = fallEn && active && lastBit;
    stb.frameStart = syncRise;
    stb.slot       = slotCnt;
    stb.bitIdx     = bitCnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncSeen <= 1'b0;
      active   <= 1'b0;
      slotCnt  <= '0;
      bitCnt   <= '0;
    end else if (fallEn) begin
      syncSeen <= syncIn;
      if (syncRise) begin
        active  <= 1'b1;
        slotCnt <= '0;
        bitCnt  <= '0;
      end else if (active) begin
        if (lastBit) begin
          bitCnt  <= '0;
          slotCnt <= slotCnt + 1'b1;
          if (slotCnt == SLOT_IDX_W'(NUM_SLOTS)) active <= 1'b0;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/aclink_datapath.sv
module aclink_datapath
  import aclink_pkg::*;
#(
  parameter int CAP_W = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  linkStrobes_t       stb,
  input  logic               rxData,
  input  logic               codecReady,
  input  logic               statusValid,
  input  logic [6:0]         statusIndex,
  input  logic [15:0]        statusData,
  input  logic               captureValid,
  input  logic [CAP_W-1:0]   captureLeft,
  input  logic [CAP_W-1:0]   captureRight,
  output logic               txData,
  output logic [NUM_FWD-1:0] slotStrobe,
  output logic [SLOT_W-1:0]  slotWord
);
  localparam int PAD = SLOT_W - CAP_W;

  logic [SLOT_W-1:0]  rxShift, shiftNext, txWord;
  logic [TAG_W-1:0]   tagReg;
  logic [NUM_FWD-1:0] strobeNext;
  logic [BIT_IDX_W-1:0] txSel;
  logic               frReady, frStatV, frCapV;
  logic [6:0]         frIdx;
  logic [15:0]        frData;
  logic [CAP_W-1:0]   frCapL, frCapR;

  assign shiftNext = {rxShift[SLOT_W-2:0], rxData};

  for (genvar i = 0; i < NUM_FWD; i++) begin : g_fwd
    assign strobeNext[i] = stb.slotEnd && (stb.slot == SLOT_IDX_W'(FWD_SLOT[i]))
                           && tagReg[TAG_W-1] && tagReg[TAG_W-1-FWD_SLOT[i]];
  end

  always_comb begin
    txWord = '0;
    case (stb.slot)
      SLOT_IDX_W'(0): txWord = {frReady, frStatV, frStatV, frCapV, frCapV, 15'b0};
      SLOT_IDX_W'(1): if (frStatV) txWord = {1'b0, frIdx, 12'b0};
      SLOT_IDX_W'(2): if (frStatV) txWord = {frData, 4'b0};
      SLOT_IDX_W'(3): if (frCapV) txWord = SLOT_W'(frCapL) << PAD;
      SLOT_IDX_W'(4): if (frCapV) txWord = SLOT_W'(frCapR) << PAD;
      default:        txWord = '0;
    endcase
    txSel = BIT_IDX_W'(SLOT_W - 1) - stb.bitIdx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxShift    <= '0;
      tagReg     <= '0;
      slotStrobe <= '0;
      slotWord   <= '0;
      txData     <= 1'b0;
      frReady    <= 1'b0;
      frStatV    <= 1'b0;
      frCapV     <= 1'b0;
      frIdx      <= '0;
      frData     <= '0;
      frCapL     <= '0;
      frCapR     <= '0;
    end else begin
      if (stb.sample) rxShift <= shiftNext;
      if (stb.slotEnd && stb.slot == '0) tagReg <= shiftNext[TAG_W-1:0];
      slotStrobe <= strobeNext;
      if (|strobeNext) slotWord <= shiftNext;
      if (stb.frameStart) begin
        frReady <= codecReady;
        frStatV <= statusValid;
        frIdx   <= statusIndex;
        frData  <= statusData;
        frCapV  <= captureValid;
        frCapL  <= captureLeft;
        frCapR  <= captureRight;
      end
      if (stb.launch) txData <= stb.active ? txWord[txSel] : 1'b0;
    end
  end
endmodule

// File: rtl/aclink_frame_engine.sv
module aclink_frame_engine
  import aclink_pkg::*;
#(
  parameter int CAP_W = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               riseEn,
  input  logic               fallEn,
  input  logic               syncIn,
  input  logic               rxData,
  output logic               txData,
  input  logic               codecReady,
  input  logic               statusValid,
  input  logic [6:0]         statusIndex,
  input  logic [15:0]        statusData,
  input  logic               captureValid,
  input  logic [CAP_W-1:0]   captureLeft,
  input  logic [CAP_W-1:0]   captureRight,
  output logic [NUM_FWD-1:0] slotStrobe,
  output logic [SLOT_W-1:0]  slotWord
);
  linkStrobes_t stb;

  aclink_control u_ctrl (
    .clk(clk), .rst_n(rst_n), .riseEn(riseEn), .fallEn(fallEn),
    .syncIn(syncIn), .stb(stb)
  );

  aclink_datapath #(.CAP_W(CAP_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .rxData(rxData),
    .codecReady(codecReady), .statusValid(statusValid),
    .statusIndex(statusIndex), .statusData(statusData),
    .captureValid(captureValid), .captureLeft(captureLeft),
    .captureRight(captureRight), .txData(txData),
    .slotStrobe(slotStrobe), .slotWord(slotWord)
  );
endmodule

// File: rtl/aclink_frame_engine_chk.sv
module aclink_frame_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       riseEn,
  input logic       fallEn,
  input logic       txData,
  input logic [5:0] slotStrobe
);
  // R2
  tx_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(riseEn) |-> $stable(txData));
  // R7
  strobe_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|slotStrobe) |-> $past(fallEn));
  // R7
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|slotStrobe) |=> !(|slotStrobe));
  // R8
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slotStrobe));
endmodule

bind aclink_frame_engine aclink_frame_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .riseEn(riseEn), .fallEn(fallEn),
  .txData(txData), .slotStrobe(slotStrobe)
);

// File: tb/aclink_frame_engine_test.sv
module aclink_frame_engine_test;
  typedef struct packed {
    logic        ready;
    logic        sv;
    logic [6:0]  idx;
    logic [15:0] data;
    logic        cv;
    logic [17:0] capL;
    logic [17:0] capR;
  } ret_t;

  logic clk = 0, rst_n = 0, riseEn = 0, fallEn = 0, syncIn = 0, rxData = 0;
  logic txData;
  logic [5:0] slotStrobe;
  logic [19:0] slotWord;
  ret_t drv, snap;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  aclink_frame_engine uut (
    .clk(clk), .rst_n(rst_n), .riseEn(riseEn), .fallEn(fallEn),
    .syncIn(syncIn), .rxData(rxData), .txData(txData),
    .codecReady(drv.ready), .statusValid(drv.sv), .statusIndex(drv.idx),
    .statusData(drv.data), .captureValid(drv.cv), .captureLeft(drv.capL),
    .captureRight(drv.capR), .slotStrobe(slotStrobe), .slotWord(slotWord)
  );

  task automatic chk(input logic ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic int fwdBit(int s);
    case (s) 1: return 0; 2: return 1; 3: return 2; 4: return 3;
      7: return 4; 8: return 5; default: return -1; endcase
  endfunction

  // expected return bit at frame position p, from R3/R4/R5
  function automatic logic txExp(ret_t c, int p);
    logic [15:0] t; logic [19:0] w; int s, b;
    if (p < 16) begin
      t = {c.ready, c.sv, c.sv, c.cv, c.cv, 11'b0};
      return t[15-p];
    end
    s = (p - 16) / 20 + 1; b = (p - 16) % 20; w = '0;
    case (s)
      1: if (c.sv) w = {1'b0, c.idx, 12'b0};
      2: if (c.sv) w = {c.data, 4'b0};
      3: if (c.cv) w = {c.capL, 2'b0};
      4: if (c.cv) w = {c.capR, 2'b0};
      default: w = '0;
    endcase
    return w[19-b];
  endfunction

  // one bit period: launch cycle, gap, sample cycle, then check (R1, R2)
  task automatic bitStep(input logic s, input logic d, input logic expTx,
                         input logic [5:0] es, input logic [19:0] ew, input string rq);
    @(negedge clk) riseEn = 1; syncIn = s; rxData = d;
    @(negedge clk) riseEn = 0;
    @(negedge clk) fallEn = 1;
    @(negedge clk) fallEn = 0;
    chk(txData === expTx, rq, 32'(txData), 32'(expTx), "txData");
    chk(slotStrobe === es, (es != 0) ? "R7" : "R8", 32'(slotStrobe), 32'(es), "slotStrobe");
    if (es != 0) chk(slotWord === ew, "R7", 32'(slotWord), 32'(ew), "slotWord");
  endtask

  task automatic runFrame(input logic v, input logic [11:0] tags, input int seed,
                          input int len, input logic follow, input ret_t nxt);
    logic [0:11][19:0] w; logic [255:0] fr; ret_t cur;
    for (int k = 0; k < 12; k++) w[k] = 20'(seed * 7919 + (k + 1) * 40503);
    fr = {v, tags, 3'b000, w};
    cur = snap;
    for (int p = 0; p < len; p++) begin
      logic s; logic [5:0] es; logic [19:0] ew; int sl; int fb; string rq;
      if (p == 60) drv = nxt; // mid return slot 3: must not leak (R6)
      s = (p < 15) || (p == len - 1 && follow);
      es = '0; ew = '0;
      if (p >= 16 && (p - 16) % 20 == 19) begin
        sl = (p - 16) / 20 + 1;
        fb = fwdBit(sl);
        if (fb >= 0 && v && tags[12-sl]) begin es[fb] = 1'b1; ew = w[sl-1]; end
      end
      rq = (p < 16) ? "R3" : (p < 56) ? "R4" : (p < 96) ? "R5/R6" : "R5";
      bitStep(s, fr[255-p], txExp(cur, p), es, ew, rq);
      if (p == len - 1 && follow) snap = drv;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    drv = '{1'b1, 1'b1, 7'h26, 16'hA5C3, 1'b1, 18'h2ABCD, 18'h15432};
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(txData === 1'b0, "R11", 32'(txData), 0, "txData in reset");
    chk(slotStrobe === 6'b0, "R11", 32'(slotStrobe), 0, "slotStrobe in reset");
    rst_n = 1;
    @(negedge clk);
    chk(txData === 1'b0, "R11", 32'(txData), 0, "txData after reset");
    // R1: lead sync rise
    bitStep(1'b1, 1'b0, 1'b0, 6'b0, 20'b0, "R1");
    snap = drv;
    // all slots tagged: only 1,2,3,4,7,8 strobe (R7, R8)
    runFrame(1'b1, 12'hFFF, 1, 256, 1'b1,
             '{1'b0, 1'b0, 7'h00, 16'h0000, 1'b1, 18'h3FFFF, 18'h00001});
    // frame-valid clear: no strobes (R8)
    runFrame(1'b0, 12'hFFF, 2, 256, 1'b1,
             '{1'b1, 1'b1, 7'h7C, 16'h0001, 1'b0, 18'h0, 18'h0});
    // only slots 3 and 8 tagged
    runFrame(1'b1, 12'h210, 3, 256, 1'b1,
             '{1'b1, 1'b0, 7'h00, 16'h0000, 1'b1, 18'h20000, 18'h1FFFF});
    // R9: sync rise at bit 99 restarts
    runFrame(1'b1, 12'hFFF, 4, 100, 1'b1,
             '{1'b1, 1'b1, 7'h02, 16'hFFFF, 1'b1, 18'h12345, 18'h0F0F0});
    runFrame(1'b1, 12'hF30, 5, 256, 1'b0,
             '{1'b0, 1'b1, 7'h55, 16'h8001, 1'b0, 18'h0, 18'h0});
    // R10: idle without sync
    for (int i = 0; i < 40; i++) bitStep(1'b0, i[0], 1'b0, 6'b0, 20'b0, "R10");
    // R1: new sync rise after idle; only ignored slots tagged (R8)
    bitStep(1'b1, 1'b0, 1'b0, 6'b0, 20'b0, "R1");
    snap = drv;
    runFrame(1'b1, 12'h0CF, 6, 256, 1'b0, drv);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule